// File: doc/BRIEF.md
# Serial Management Link Command Frame Encoder

This block turns one host command into a serial frame on a two-line management link. The master drives the link clock. The data line is bidirectional, and this block holds it in output mode. Four commands are supported: an absolute-address read, an absolute-address write, a data poll and a terminate. Each is addressed to one of four slaves.

The host presents the command kind, slave number, address, transfer size and write data together with a valid strobe. The encoder captures them and emits a start bit, then the message bits most-significant bit first, then a 4-bit CRC. Each bit takes one link clock period. While the frame is in flight the host is held off with `busy`. A one-cycle `done` marks the end of the frame. Response handling belongs to a separate receiver.

The wire data is active-low. The CRC covers the start bit as well as the message. The transfer size travels in the two lowest address bits together with a single size flag.

Top module: `mgmt_cmd_tx`

## Requirements
- R1: After reset `link_clk` and `link_data` are both 1, `busy` and `done` are 0, and `link_oe` is 0. Whenever `busy` is 0, both link lines are 1.
- R2: A command is taken when `cmd_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the frame ends. A `cmd_valid` raised while `busy` is 1 is ignored: the frame in flight is unchanged and no second frame follows.
- R3: Each bit spans two system clock cycles, with `link_clk` 0 in the first and 1 in the second. `link_data` changes only in the cycle where `link_clk` goes low, and it holds through the high half.
- R4: Wire data is active-low, so a logical 1 drives `link_data` to 0. The first bit of every frame is a start bit of logical 1.
- R5: `cmd_kind` 0 is a read and 1 is a write. Either one sends the 2-bit slave id, then opcode 3'b100, then a direction bit (1 for read, 0 for write), then 21 address bits, then a size flag.
- R6: `size_sel` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 selects 4 bytes. The size flag is 0 only for 1 byte. For 2 bytes, address bit 0 is sent as 0. For 4 bytes, address bit 1 is sent as 0 and address bit 0 as 1.
- R7: A write appends its data after the size flag, most-significant byte first, taken from the low 1, 2 or 4 bytes of `wdata`. A read appends no data.
- R8: `cmd_kind` 2 (data poll) sends the slave id and then 3'b010. `cmd_kind` 3 (terminate) sends the slave id and then 6'b111111.
- R9: The last four bits are a CRC using x^4+x+1, starting from zero and processed MSB-first, over the start bit and all message bits. The CRC is sent most-significant bit first.
- R10: `done` is 1 for exactly one cycle, the first cycle after the last bit's high half. `busy` falls in that same cycle. A frame of N bits, start and CRC included, holds `busy` for 2N cycles.
- R11: `link_oe` rises together with `busy` on the first command and stays 1 after that until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 2 | 0 read, 1 write, 2 data poll, 3 terminate |
| slave_id | input | 2 | Target slave number |
| addr | input | 21 | Byte address for read or write |
| size_sel | input | 2 | Transfer size code |
| wdata | input | 32 | Write data, low bytes used for short sizes |
| busy | output | 1 | Frame in flight; new commands ignored |
| done | output | 1 | One-cycle end-of-frame pulse |
| link_clk | output | 1 | Link clock line, idles high |
| link_data | output | 1 | Link data line, active-low, idles high |
| link_oe | output | 1 | Data line output enable |

## Verification
The assertions assume the host raises `cmd_valid` only between frames, or mid-frame only to test that it is ignored. They also assume reset is applied once before traffic. The bench drives all inputs on the falling system clock edge. It raises `cmd_valid` for a single cycle per command, except for deliberate mid-frame strobes that end before the frame does. The sweep walks every slave id, every command kind and every size code, with addresses and data chosen so that folded address bits and byte order would show any error.

// File: rtl/mgmt_cmd_pkg.sv
package mgmt_cmd_pkg;
  localparam int ID_W   = 2;
  localparam int DATA_W = 32;
  localparam int CRC_W  = 4;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_POLL  = 2'd2,
    K_TERM  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_MSG   = 2'd2,
    S_CRC   = 2'd3
  } seq_state_e;

  // one MSB-first step of the x^4+x+1 CRC
  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2], c[1], c[0] ^ fb, fb};
  endfunction

  // size code to size flag
  function automatic logic size_flag(input logic [1:0] sz);
    return sz != 2'd0;
  endfunction

  // low two address bits after folding in the size
  function automatic logic [1:0] fold_low2(input logic [1:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return a;
      2'd1:    return {a[1], 1'b0};
      default: return 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/mgmt_frame_builder.sv
module mgmt_frame_builder
  import mgmt_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int HDR_W  = ID_W + 5 + ADDR_W,
  parameter int MSG_W  = HDR_W + DATA_W,
  parameter int LEN_W  = $clog2(MSG_W + 1)
) (
  input  logic [1:0]        kind,
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        sz,
  input  logic [DATA_W-1:0] wdata,
  output logic [MSG_W-1:0]  msg,
  output logic [LEN_W-1:0]  len
);
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] payload;
  logic [ADDR_W-1:0] faddr;

  always_comb begin
    faddr = {addr[ADDR_W-1:2], fold_low2(addr[1:0], sz)};
    hdr   = {id, 3'b100, (kind == K_READ), faddr, size_flag(sz)};
    case (sz)
      2'd0:    payload = {wdata[7:0], {(DATA_W-8){1'b0}}};
      2'd1:    payload = {wdata[15:0], {(DATA_W-16){1'b0}}};
      default: payload = wdata;
    endcase
    msg = '0;
    len = '0;
    case (kind)
      K_READ: begin
        msg = {hdr, {DATA_W{1'b0}}};
        len = LEN_W'(HDR_W);
      end
      K_WRITE: begin
        msg = {hdr, payload};
        case (sz)
          2'd0:    len = LEN_W'(HDR_W + 8);
          2'd1:    len = LEN_W'(HDR_W + 16);
          default: len = LEN_W'(HDR_W + DATA_W);
        endcase
      end
      K_POLL: begin
        msg = {id, 3'b010, {(MSG_W-ID_W-3){1'b0}}};
        len = LEN_W'(ID_W + 3);
      end
      default: begin
        msg = {id, 6'b111111, {(MSG_W-ID_W-6){1'b0}}};
        len = LEN_W'(ID_W + 6);
      end
    endcase
  end
endmodule

// File: rtl/mgmt_crc_accum.sv
module mgmt_crc_accum
  import mgmt_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             shift,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (clear)  crc <= '0;
    else if (step)   crc <= crc4_step(crc, bit_in);
    else if (shift)  crc <= {crc[CRC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/mgmt_link_shifter.sv
module mgmt_link_shifter
  import mgmt_cmd_pkg::*;
#(
  parameter int MSG_W = 60,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [MSG_W-1:0] msg,
  input  logic [LEN_W-1:0] len,
  input  logic [CRC_W-1:0] crc,
  output logic             busy,
  output logic             done,
  output logic             phase_hi,
  output logic             oe,
  output logic             cur_bit,
  output logic             advance,
  output logic             crc_step,
  output logic             crc_shift
);
  seq_state_e       state;
  logic [MSG_W-1:0] shreg;
  logic [LEN_W-1:0] cnt;

  assign busy      = (state != S_IDLE);
  assign advance   = busy && phase_hi;
  assign crc_step  = advance && (state == S_START || state == S_MSG);
  assign crc_shift = advance && (state == S_CRC);

  always_comb begin
    case (state)
      S_START: cur_bit = 1'b1;
      S_MSG:   cur_bit = shreg[MSG_W-1];
      S_CRC:   cur_bit = crc[CRC_W-1];
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      phase_hi <= 1'b0;
      done     <= 1'b0;
      oe       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state    <= S_START;
        shreg    <= msg;
        cnt      <= len;
        phase_hi <= 1'b0;
        oe       <= 1'b1;
      end else if (busy && !phase_hi) begin
        phase_hi <= 1'b1;
      end else if (advance) begin
        phase_hi <= 1'b0;
        case (state)
          S_START: state <= S_MSG;
          S_MSG: begin
            shreg <= {shreg[MSG_W-2:0], 1'b0};
            if (cnt == LEN_W'(1)) begin
              state <= S_CRC;
              cnt   <= LEN_W'(CRC_W);
            end else begin
              cnt <= cnt - LEN_W'(1);
            end
          end
          default: begin
            if (cnt == LEN_W'(1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              cnt <= cnt - LEN_W'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mgmt_cmd_tx.sv
module mgmt_cmd_tx
  import mgmt_cmd_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ID_W-1:0]   slave_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              link_clk,
  output logic              link_data,
  output logic              link_oe
);
  localparam int HDR_W = ID_W + 5 + ADDR_W;
  localparam int MSG_W = HDR_W + DATA_W;
  localparam int LEN_W = $clog2(MSG_W + 1);

  logic [MSG_W-1:0] msg;
  logic [LEN_W-1:0] len;
  logic [CRC_W-1:0] crc;
  logic frame_accept, bit_advance, crc_step, crc_shift, cur_bit, phase_hi;

  assign frame_accept = cmd_valid && !busy;

  mgmt_frame_builder #(.ADDR_W(ADDR_W), .HDR_W(HDR_W), .MSG_W(MSG_W), .LEN_W(LEN_W)) u_build (
    .kind(cmd_kind), .id(slave_id), .addr(addr), .sz(size_sel), .wdata(wdata),
    .msg(msg), .len(len)
  );

  mgmt_crc_accum u_crc (
    .clk(clk), .rst_n(rst_n), .clear(frame_accept), .step(crc_step),
    .shift(crc_shift), .bit_in(cur_bit), .crc(crc)
  );

  mgmt_link_shifter #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .accept(frame_accept), .msg(msg), .len(len),
    .crc(crc), .busy(busy), .done(done), .phase_hi(phase_hi), .oe(link_oe),
    .cur_bit(cur_bit), .advance(bit_advance), .crc_step(crc_step),
    .crc_shift(crc_shift)
  );

  assign link_clk  = busy ? phase_hi : 1'b1;
  assign link_data = busy ? ~cur_bit : 1'b1;
endmodule

// File: rtl/mgmt_cmd_tx_chk.sv
module mgmt_cmd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic link_clk,
  input logic link_data,
  input logic link_oe,
  input logic frame_accept,
  input logic bit_advance
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (link_clk && link_data));
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> busy);
  a_r3_clk_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (link_clk != $past(link_clk)));
  a_r3_data_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && link_clk) |-> $stable(link_data));
  a_r3_advance_high: assert property (@(posedge clk) disable iff (!rst_n)
    bit_advance |-> link_clk);
  a_r4_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> (!link_data && !link_clk));
  a_r10_done_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    link_oe |=> link_oe);
endmodule

bind mgmt_cmd_tx mgmt_cmd_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .link_clk(link_clk),
  .link_data(link_data), .link_oe(link_oe), .frame_accept(frame_accept),
  .bit_advance(bit_advance)
);

// File: tb/mgmt_cmd_tx_bench.sv
module mgmt_cmd_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [1:0] slave_id = 2'd0;
  logic [20:0] addr = '0;
  logic [1:0] size_sel = 2'd0;
  logic [31:0] wdata = '0;
  logic busy, done, link_clk, link_data, link_oe;

  int n_tests = 0;
  int n_fail = 0;
  logic exp_bits [0:127];
  logic cap_bits [0:127];
  int exp_n, cap_n;

  always #2.5 clk = ~clk;

  mgmt_cmd_tx u_mgmt_cmd_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .slave_id(slave_id), .addr(addr), .size_sel(size_sel), .wdata(wdata),
    .busy(busy), .done(done), .link_clk(link_clk), .link_data(link_data),
    .link_oe(link_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      exp_bits[exp_n] = v[i];
      exp_n = exp_n + 1;
    end
  endtask

  // remainder of the bit string times x^4 modulo 10011
  task automatic append_crc();
    logic [4:0] r;
    int m;
    r = '0;
    m = exp_n;
    for (int i = 0; i < m + 4; i++) begin
      r = {r[3:0], (i < m) ? exp_bits[i] : 1'b0};
      if (r[4]) r = r ^ 5'b10011;
    end
    push({60'b0, r[3:0]}, 4);
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req, input string what);
    int bad;
    bad = -1;
    for (int i = lo; i < hi; i++)
      if (bad < 0 && cap_bits[i] !== exp_bits[i]) bad = i;
    check(bad < 0, req, what, (bad < 0) ? 0 : longint'(cap_bits[bad]),
          (bad < 0) ? 0 : longint'(exp_bits[bad]));
  endtask

  task automatic run_cmd(input logic [1:0] k, input logic [1:0] id, input logic [20:0] a,
                         input logic [1:0] sz, input logic [31:0] wd, input bit intrude);
    logic [20:0] fa;
    int nb, cyc, hdr_end;
    logic prev_clk, low_val;
    bit stable_ok, oe_ok;
    exp_n = 0;
    push(64'd1, 1);
    push({62'b0, id}, 2);
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (sz == 2'd0) fa = a;
    else if (sz == 2'd1) fa = a & ~21'd1;
    else fa = (a & ~21'd3) | 21'd1;
    if (k <= 2'd1) begin
      push(64'd4, 3);
      push({63'b0, k == 2'd0}, 1);
      push({43'b0, fa}, 21);
      push({63'b0, sz != 2'd0}, 1);
      if (k == 2'd1) push({32'b0, wd} & ((64'd1 << (8 * nb)) - 1), 8 * nb);
    end else if (k == 2'd2) push(64'd2, 3);
    else push(64'h3f, 6);
    hdr_end = exp_n;
    append_crc();

    @(negedge clk);
    cmd_kind = k; slave_id = id; addr = a; size_sel = sz; wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1, "R2", "busy after accept", busy, 1);
    cyc = 0; cap_n = 0; prev_clk = 1'b1; low_val = 1'b0; stable_ok = 1; oe_ok = 1;
    while (busy === 1'b1 && cyc < 400) begin
      if (link_oe !== 1'b1) oe_ok = 0;
      if (link_clk === 1'b0) low_val = link_data;
      else if (prev_clk === 1'b0) begin
        cap_bits[cap_n] = ~link_data;
        cap_n = cap_n + 1;
        if (link_data !== low_val) stable_ok = 0;
      end
      prev_clk = link_clk;
      if (intrude && cyc == 3) begin cmd_valid = 1'b1; cmd_kind = ~k; end
      if (intrude && cyc == 6) cmd_valid = 1'b0;
      cyc++;
      @(negedge clk);
    end
    check(done === 1'b1, "R10", "done at end", done, 1);
    check(cyc == 2 * exp_n, "R10", "busy cycles", cyc, 2 * exp_n);
    check(cap_n == exp_n, "R3", "bit count", cap_n, exp_n);
    check(stable_ok, "R3", "data held in high half", 0, 1);
    check(oe_ok, "R11", "oe during frame", 0, 1);
    if (cap_n == exp_n) begin
      check(cap_bits[0] === 1'b1, "R4", "start bit", cap_bits[0], 1);
      if (k <= 2'd1) begin
        cmp_range(1, 30, "R5", "header bits");
        cmp_range(25, 30, "R6", "folded address and size flag");
        if (k == 2'd1) cmp_range(30, hdr_end, "R7", "write data bits");
      end else cmp_range(1, hdr_end, "R8", "poll/term bits");
      cmp_range(hdr_end, exp_n, "R9", "crc bits");
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R2", "no second frame, done pulse ends",
          {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(link_clk === 1'b1 && link_data === 1'b1, "R1", "idle lines in reset",
          {link_clk, link_data}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    check(link_oe === 1'b0, "R11", "oe after reset", link_oe, 0);
    for (int id = 0; id < 4; id++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int ap = 0; ap < 4; ap++) begin
          logic [20:0] av;
          av = (ap == 0) ? 21'h000000 : (ap == 1) ? 21'h1fffff :
               (ap == 2) ? 21'h0aaaa6 : 21'h155559;
          run_cmd(2'd0, 2'(id), av, 2'(sz), 32'h0, 1'b0);
          run_cmd(2'd1, 2'(id), av, 2'(sz), 32'h8143c2a5 ^ {4{8'(ap * 37 + id)}}, ap == 3);
        end
      end
      run_cmd(2'd2, 2'(id), 21'h0, 2'd0, 32'h0, 1'b0);
      run_cmd(2'd3, 2'(id), 21'h0, 2'd0, 32'h0, id == 1);
    end
    check(link_oe === 1'b1, "R11", "oe stays high between frames", link_oe, 1);
    check(link_clk === 1'b1 && link_data === 1'b1, "R1", "idle lines after traffic",
          {link_clk, link_data}, 3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule